// File: doc/BRIEF.md
# Memory-Mapped Display Output Port

This block connects a processor to a character display over a 16-bit memory-mapped bus. It has two registers. The status register shows software whether the display can take a new character, and it holds an interrupt enable bit. When software writes the data register while the display is free, the port captures the low byte and passes it to the display with a one-cycle strobe. The port then reports busy until the display returns a done pulse.

Software has two ways to wait for the display. It can poll the ready bit. It can also set the interrupt enable bit and wait for the interrupt request. A write to the data register while the display is busy is dropped; the port has no queue. Bus reads are combinational on the address.

Top module: `disp_port`

## Requirements
- R1: After reset, ready is 1 and interrupt enable is 0. The status register reads 0x8000, irq is 0 and char_valid is 0.
- R2: A read at address 0xFE04 returns ready in bit 15 and interrupt enable in bit 14. All other bits read 0.
- R3: A write to 0xFE04 loads interrupt enable from wdata bit 14 and changes nothing else.
- R4: A write to 0xFE06 while ready is 1 is accepted. In the next cycle, char_valid is 1 for exactly one cycle, char_code equals wdata[7:0] and ready is 0. The upper write byte is dropped.
- R5: A write to 0xFE06 while ready is 0 is ignored: no strobe occurs and char_code keeps its value.
- R6: A disp_done pulse while ready is 0 makes ready 1 in the next cycle. If an accepted write and disp_done arrive in the same cycle, the write wins and ready goes to 0.
- R7: irq is 1 exactly when ready and interrupt enable are both 1.
- R8: A read at 0xFE06 returns the last accepted character in bits [7:0] and zero in bits [15:8].
- R9: Reads of any other address return 0, and writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| disp_done | input | 1 | One-cycle pulse from the display when it finishes a character |
| char_valid | output | 1 | One-cycle strobe when a character is handed to the display |
| char_code | output | 8 | The character being handed to the display |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 16-bit bus, an 8-bit character, and the status and data registers at 0xFE04 and 0xFE06. With these values, a write to the odd address between the two registers shows that address decoding is exact. Full 16-bit write patterns show that only bit 14 of the status register and only the low byte of the data register are taken. The vectors also cover the case where a write and a done pulse land in the same cycle, both while the display is free and while it is busy. In that case, which event wins decides the state of ready.

// File: rtl/disp_port.sv
module disp_port #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
  parameter int RDY_BIT   = 15,
  parameter int IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              disp_done,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_code,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CHAR_W;

  logic ready_q, ie_q, cv_q;
  logic [CHAR_W-1:0] chr_q;

  wire sel_stat = (bus_addr == STAT_ADDR);
  wire sel_data = (bus_addr == DATA_ADDR);
  wire accept   = bus_wr & sel_data & ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
      ie_q    <= 1'b0;
      cv_q    <= 1'b0;
      chr_q   <= '0;
    end else begin
      cv_q <= accept;
      if (accept) begin
        chr_q   <= bus_wdata[CHAR_W-1:0];
        ready_q <= 1'b0;
      end else if (disp_done) begin
        ready_q <= 1'b1;
      end
      if (bus_wr && sel_stat) ie_q <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_stat) begin
      bus_rdata[RDY_BIT] = ready_q;
      bus_rdata[IE_BIT]  = ie_q;
    end else if (sel_data) begin
      bus_rdata = {{PAD_W{1'b0}}, chr_q};
    end
  end

  assign char_valid = cv_q;
  assign char_code  = chr_q;
  assign irq        = ready_q & ie_q;
endmodule

// File: rtl/disp_port_chk.sv
module disp_port_chk #(
  parameter int ADDR_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              disp_done,
  input logic              char_valid,
  input logic [CHAR_W-1:0] char_code,
  input logic              irq,
  input logic              ready_q
);
  wire wr_data = bus_wr && (bus_addr == DATA_ADDR);

  p_accept_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ready_q) |=> (char_valid && !ready_q));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |=> !char_valid);

  p_busy_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_q |=> (!char_valid && $stable(char_code)));

  p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_q && disp_done) |=> ready_q);

  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && ready_q) |=> !irq);

  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data && ready_q) |=> $stable(char_code));
endmodule

bind disp_port disp_port_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .disp_done(disp_done), .char_valid(char_valid), .char_code(char_code),
  .irq(irq), .ready_q(ready_q)
);

// File: tb/disp_port_test.sv
module disp_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic disp_done = 1'b0;
  logic char_valid;
  logic [7:0] char_code;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  disp_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .disp_done(disp_done),
    .char_valid(char_valid), .char_code(char_code), .irq(irq)
  );

  localparam logic [15:0] ST = 16'hFE04;
  localparam logic [15:0] DR = 16'hFE06;

  // {wr, addr, wdata, done, exp_cv, exp_code, exp_status, exp_irq}
  localparam int NV = 12;
  localparam logic [59:0] VEC [NV] = '{
    {1'b1, ST, 16'hFFFF, 1'b0, 1'b0, 8'h00, 16'hC000, 1'b1},      // R3 R7
    {1'b1, DR, 16'h1241, 1'b0, 1'b1, 8'h41, 16'h4000, 1'b0},      // R4
    {1'b0, ST, 16'h0000, 1'b0, 1'b0, 8'h41, 16'h4000, 1'b0},      // R4
    {1'b1, DR, 16'h0042, 1'b0, 1'b0, 8'h41, 16'h4000, 1'b0},      // R5
    {1'b0, ST, 16'h0000, 1'b1, 1'b0, 8'h41, 16'hC000, 1'b1},      // R6
    {1'b1, DR, 16'hAB5A, 1'b1, 1'b1, 8'h5A, 16'h4000, 1'b0},      // R6
    {1'b1, ST, 16'h0000, 1'b0, 1'b0, 8'h5A, 16'h0000, 1'b0},      // R3
    {1'b0, ST, 16'h0000, 1'b1, 1'b0, 8'h5A, 16'h8000, 1'b0},      // R6 R7
    {1'b1, 16'hFE05, 16'hFFFF, 1'b0, 1'b0, 8'h5A, 16'h8000, 1'b0}, // R9
    {1'b1, ST, 16'h4000, 1'b0, 1'b0, 8'h5A, 16'hC000, 1'b1},      // R2
    {1'b1, DR, 16'h0030, 1'b0, 1'b1, 8'h30, 16'h4000, 1'b0},      // R4
    {1'b1, DR, 16'h0031, 1'b1, 1'b0, 8'h30, 16'hC000, 1'b1}       // R5 R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    bus_addr = ST;
    #1;
    check("R1 status", bus_rdata, 16'h8000);
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 char_valid", {15'b0, char_valid}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr    = VEC[i][59];
      bus_addr  = VEC[i][58:43];
      bus_wdata = VEC[i][42:27];
      disp_done = VEC[i][26];
      @(posedge clk);
      #1;
      bus_wr = 1'b0; disp_done = 1'b0; bus_addr = ST;
      #2;
      check($sformatf("R4 vec%0d char_valid", i), {15'b0, char_valid}, {15'b0, VEC[i][25]});
      check($sformatf("R5 vec%0d char_code", i), {8'b0, char_code}, {8'b0, VEC[i][24:17]});
      check($sformatf("R2 vec%0d status", i), bus_rdata, VEC[i][16:1]);
      check($sformatf("R7 vec%0d irq", i), {15'b0, irq}, {15'b0, VEC[i][0]});
    end

    bus_addr = DR; #1;
    check("R8 data read", bus_rdata, 16'h0030);
    bus_addr = 16'hFE05; #1;
    check("R9 other read", bus_rdata, 16'h0000);
    bus_addr = 16'h0000; #1;
    check("R9 zero addr read", bus_rdata, 16'h0000);

    @(negedge clk);
    bus_wr = 1'b1; bus_addr = DR; bus_wdata = 16'hFF7E;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = ST;
    check("R4 strobe first", {15'b0, char_valid}, 16'h1);
    check("R4 upper byte dropped", {8'b0, char_code}, 16'h007E);
    @(negedge clk);
    check("R4 strobe one cycle", {15'b0, char_valid}, 16'h0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_addr = ST; #1;
    check("R1 status after reset", bus_rdata, 16'h8000);
    check("R1 irq after reset", {15'b0, irq}, 16'h0);
    bus_addr = DR; #1;
    check("R1 data after reset", bus_rdata, 16'h0000);

    finish_run();
  end
endmodule